// File: doc/BRIEF.md
# Bus Error Capture and Status Register

This block keeps a small record of failed bus transactions for software. When the surrounding bus logic reports an error, the failing address is kept in the first free entry of two log entries. The status word then shows which entries hold a valid record. A sticky flag is raised when an error arrives while both entries are already taken. In that case the stored records are kept as they are. The same status word also shows, read-only, whether the bus still has transactions outstanding.

Software reaches the block through a plain register port. A register is named by a register number, a secondary selector and two operation fields. Index 0 is the status word, and indices 1 and 2 return the two logged addresses. Software clears the three flags by writing 1 to them. The error-report input is a plain strobe that is taken on every cycle it is high. It is never held off, so it has no ready pin and no back-pressure. A write to the register port changes state at the clock edge where it is presented. Read data is combinational from the selected register.

Top module: `bus_err_log`

## Requirements
- R1: Status bit 31 equals the `txn_pending` input whenever the status word is read. A write to the status word never changes bit 31.
- R2: Writing 1 to status bit 30 clears the overflow flag. Writing 1 to bit 29 clears the entry-1 valid flag, and writing 1 to bit 28 clears the entry-0 valid flag. Writing 0 to any of these bits leaves that flag unchanged.
- R3: An error strobe that arrives while both valid flags are 1 sets the overflow flag (bit 30). Both logged addresses stay unchanged.
- R4: An error strobe stores `err_addr` in entry 0 and sets bit 28 if entry 0 is not valid. Otherwise it stores the address in entry 1 and sets bit 29 if entry 1 is not valid. Entry 0 reads at index 1 and entry 1 reads at index 2.
- R5: After reset, all three flags are 0 and both logged addresses read 0.
- R6: Status bits 27:0 always read 0, whatever value was written to them.
- R7: A register is selected only when the secondary selector is 1, both operation fields are 0 and the register number is 0, 1 or 2. Any other selection reads 0, and a write to it changes nothing.
- R8: Entry selection uses the flags held at the start of the cycle. If an error would set a flag in the same cycle that software clears that flag, the set wins.
- R9: A logged address does not change while its valid flag is 1. Writes to indices 1 and 2 have no effect.
- R10: A read in the cycle after a write returns the value left by that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_pending | input | 1 | High while any bus transaction is outstanding |
| err_valid | input | 1 | Error report strobe, taken on every cycle it is high |
| err_addr | input | ADDR_W | Address of the failing transaction |
| reg_num | input | NUM_W | Register number field |
| reg_sub | input | SUB_W | Secondary selector, must be 1 |
| reg_opa | input | OP_W | First operation field, must be 0 |
| reg_opb | input | OP_W | Second operation field, must be 0 |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register (combinational) |

## Verification
A flag that is wrong inside the block shows up in the status word in the first cycle after the faulty update. One wrong flag also sends the next error to the wrong log entry. That shows up at index 1 or 2, or as a missing or extra overflow, on the next read. The bench sweeps every start state of the three flags against every clear mask, with and without an error in the same cycle, and reads all three registers one cycle later. It also sweeps every selector combination, so a decode fault shows up as a wrong or missing read value on the same cycle.

// File: rtl/bel_pkg.sv
package bel_pkg;
  localparam int unsigned STAT_BUSY_BIT = 31;
  localparam int unsigned STAT_OVF_BIT  = 30;
  localparam int unsigned STAT_V1_BIT   = 29;
  localparam int unsigned STAT_V0_BIT   = 28;
  localparam int unsigned LOG_ENTRIES   = 2;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_LOG0   = 2'd2,
    SEL_LOG1   = 2'd3
  } bel_sel_e;

  typedef struct packed {
    logic ovf;
    logic v1;
    logic v0;
  } bel_flags_t;
endpackage

// File: rtl/bel_decode.sv
module bel_decode
  import bel_pkg::*;
#(
  parameter int unsigned NUM_W = 4,
  parameter int unsigned SUB_W = 4,
  parameter int unsigned OP_W  = 3
) (
  input  logic [NUM_W-1:0] reg_num,
  input  logic [SUB_W-1:0] reg_sub,
  input  logic [OP_W-1:0]  reg_opa,
  input  logic [OP_W-1:0]  reg_opb,
  output bel_sel_e         sel
);
  localparam logic [SUB_W-1:0] SUB_MATCH = SUB_W'(1);
  localparam logic [NUM_W-1:0] IDX_STAT  = NUM_W'(0);
  localparam logic [NUM_W-1:0] IDX_LOG0  = NUM_W'(1);
  localparam logic [NUM_W-1:0] IDX_LOG1  = NUM_W'(2);

  logic space_ok;

  always_comb begin
    space_ok = (reg_sub == SUB_MATCH) && (reg_opa == '0) && (reg_opb == '0);
    sel = SEL_NONE;
    if (space_ok) begin
      unique case (reg_num)
        IDX_STAT: sel = SEL_STATUS;
        IDX_LOG0: sel = SEL_LOG0;
        IDX_LOG1: sel = SEL_LOG1;
        default:  sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bel_alloc.sv
module bel_alloc
  import bel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_valid,
  input  bel_flags_t clr,
  output bel_flags_t flags_q,
  output logic [LOG_ENTRIES-1:0] cap
);
  logic       ovf_set;
  bel_flags_t flags_d;

  // Allocation looks at the flags held at the start of the cycle.
  always_comb begin
    cap[0]  = err_valid && !flags_q.v0;
    cap[1]  = err_valid &&  flags_q.v0 && !flags_q.v1;
    ovf_set = err_valid &&  flags_q.v0 &&  flags_q.v1;
    // A set in the same cycle as a clear wins.
    flags_d.v0  = cap[0]  | (flags_q.v0  & ~clr.v0);
    flags_d.v1  = cap[1]  | (flags_q.v1  & ~clr.v1);
    flags_d.ovf = ovf_set | (flags_q.ovf & ~clr.ovf);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/bel_log_slot.sv
module bel_log_slot #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   addr_q <= '0;
    else if (cap) addr_q <= addr_in;
  end
endmodule

// File: rtl/bus_err_log.sv
module bus_err_log
  import bel_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_W  = 4,
  parameter int unsigned SUB_W  = 4,
  parameter int unsigned OP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_pending,
  input  logic              err_valid,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [NUM_W-1:0]  reg_num,
  input  logic [SUB_W-1:0]  reg_sub,
  input  logic [OP_W-1:0]   reg_opa,
  input  logic [OP_W-1:0]   reg_opb,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int unsigned PAD_W = DATA_W - ADDR_W;

  bel_sel_e   sel;
  bel_flags_t clr;
  bel_flags_t flags_q;
  logic [LOG_ENTRIES-1:0]             cap;
  logic [LOG_ENTRIES-1:0][ADDR_W-1:0] slot_addr;

  bel_decode #(.NUM_W(NUM_W), .SUB_W(SUB_W), .OP_W(OP_W)) u_decode (
    .reg_num(reg_num), .reg_sub(reg_sub), .reg_opa(reg_opa),
    .reg_opb(reg_opb), .sel(sel)
  );

  always_comb begin
    clr = '0;
    if (reg_we && sel == SEL_STATUS) begin
      clr.ovf = reg_wdata[STAT_OVF_BIT];
      clr.v1  = reg_wdata[STAT_V1_BIT];
      clr.v0  = reg_wdata[STAT_V0_BIT];
    end
  end

  bel_alloc u_alloc (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid),
    .clr(clr), .flags_q(flags_q), .cap(cap)
  );

  for (genvar g = 0; g < LOG_ENTRIES; g++) begin : g_slot
    bel_log_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .cap(cap[g]),
      .addr_in(err_addr), .addr_q(slot_addr[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_STATUS: begin
        reg_rdata[STAT_BUSY_BIT] = txn_pending;
        reg_rdata[STAT_OVF_BIT]  = flags_q.ovf;
        reg_rdata[STAT_V1_BIT]   = flags_q.v1;
        reg_rdata[STAT_V0_BIT]   = flags_q.v0;
      end
      SEL_LOG0: reg_rdata = {{PAD_W{1'b0}}, slot_addr[0]};
      SEL_LOG1: reg_rdata = {{PAD_W{1'b0}}, slot_addr[1]};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bel_checker.sv
module bel_checker
  import bel_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_pending,
  input logic              err_valid,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input bel_sel_e          sel,
  input bel_flags_t        flags,
  input logic [LOG_ENTRIES-1:0][ADDR_W-1:0] slot_addr
);
  p_busy_mirror_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_STATUS) |-> (reg_rdata[STAT_BUSY_BIT] == txn_pending));

  p_ovf_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel == SEL_STATUS && reg_wdata[STAT_OVF_BIT] &&
     !(err_valid && flags.v0 && flags.v1)) |=> !flags.ovf);

  p_v0_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel == SEL_STATUS && reg_wdata[STAT_V0_BIT] &&
     !(err_valid && !flags.v0)) |=> !flags.v0);

  p_ovf_on_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && flags.v0 && flags.v1) |=> flags.ovf);

  p_first_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !flags.v0) |=> (flags.v0 && $stable(slot_addr[1])));

  p_reset_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flags == '0 && slot_addr == '0));

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_STATUS) |-> (reg_rdata[27:0] == '0));

  p_no_decode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (reg_rdata == '0));

  p_undecoded_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel == SEL_NONE && !err_valid) |=> $stable(flags));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !flags.v0 && reg_we && sel == SEL_STATUS) |=> flags.v0);

  p_log_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flags.v0 |=> $stable(slot_addr[0]));

  p_log_hold1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flags.v1 |=> $stable(slot_addr[1]));
endmodule

bind bus_err_log bel_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bel_checker (
  .clk(clk), .rst_n(rst_n), .txn_pending(txn_pending), .err_valid(err_valid),
  .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .sel(sel), .flags(flags_q), .slot_addr(slot_addr)
);

// File: tb/test_bus_err_log.sv
`timescale 1ns/1ps
module test_bus_err_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_pending = 1'b0;
  logic        err_valid = 1'b0;
  logic [31:0] err_addr = '0;
  logic [3:0]  reg_num = '0;
  logic [3:0]  reg_sub = 4'd1;
  logic [2:0]  reg_opa = '0;
  logic [2:0]  reg_opb = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bus_err_log i_bus_err_log (
    .clk(clk), .rst_n(rst_n), .txn_pending(txn_pending),
    .err_valid(err_valid), .err_addr(err_addr),
    .reg_num(reg_num), .reg_sub(reg_sub), .reg_opa(reg_opa), .reg_opb(reg_opb),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stat(input logic busy, input logic ov,
                                       input logic v1, input logic v0);
    return {busy, ov, v1, v0, 28'h0};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; err_valid = 1'b0; reg_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One clock edge with the given stimulus (standard selector fields).
  task automatic step(input logic e, input logic [31:0] a, input logic we,
                      input logic [3:0] num, input logic [31:0] wd);
    @(negedge clk);
    err_valid = e; err_addr = a; reg_we = we; reg_num = num;
    reg_sub = 4'd1; reg_opa = '0; reg_opb = '0; reg_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    err_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] num, input logic [3:0] sub,
                    input logic [2:0] opa, input logic [2:0] opb,
                    output logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b0; err_valid = 1'b0;
    reg_num = num; reg_sub = sub; reg_opa = opa; reg_opb = opb;
    #1 val = reg_rdata;
  endtask

  logic [31:0] v;

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R5: reset state
    rd(0, 1, 0, 0, v); check("R5 status", v, 32'h0);
    rd(1, 1, 0, 0, v); check("R5 log0", v, 32'h0);
    rd(2, 1, 0, 0, v); check("R5 log1", v, 32'h0);

    // R1 / R6: busy bit follows input, reserved bits read 0 after all-ones write
    txn_pending = 1'b1;
    rd(0, 1, 0, 0, v); check("R1 busy high", v, stat(1, 0, 0, 0));
    step(0, 0, 1, 0, 32'hFFFF_FFFF);
    txn_pending = 1'b0;
    rd(0, 1, 0, 0, v); check("R1 R6 busy low after write", v, 32'h0);

    // R4 / R3 / R9: fill entries in order, then overflow
    step(1, 32'hDEAD_0010, 0, 0, 0);
    rd(0, 1, 0, 0, v); check("R4 v0 set", v, stat(0, 0, 0, 1));
    rd(1, 1, 0, 0, v); check("R4 log0 addr", v, 32'hDEAD_0010);
    step(1, 32'hBEEF_0020, 0, 0, 0);
    rd(0, 1, 0, 0, v); check("R4 v1 set", v, stat(0, 0, 1, 1));
    rd(2, 1, 0, 0, v); check("R4 log1 addr", v, 32'hBEEF_0020);
    step(1, 32'hCAFE_0030, 0, 0, 0);
    rd(0, 1, 0, 0, v); check("R3 ovf set", v, stat(0, 1, 1, 1));
    rd(1, 1, 0, 0, v); check("R3 R9 log0 kept", v, 32'hDEAD_0010);
    rd(2, 1, 0, 0, v); check("R3 R9 log1 kept", v, 32'hBEEF_0020);

    // R9: writes to log indices do nothing
    step(0, 0, 1, 1, 32'h1234_5678);
    step(0, 0, 1, 2, 32'h8765_4321);
    rd(1, 1, 0, 0, v); check("R9 log0 write ignored", v, 32'hDEAD_0010);
    rd(2, 1, 0, 0, v); check("R9 log1 write ignored", v, 32'hBEEF_0020);
    rd(0, 1, 0, 0, v); check("R9 status after log writes", v, stat(0, 1, 1, 1));

    // R7: full selector sweep for reads
    for (int n = 0; n < 16; n++)
      for (int s = 0; s < 16; s++)
        for (int a = 0; a < 8; a++)
          for (int b = 0; b < 8; b++) begin
            logic [31:0] exp;
            exp = 32'h0;
            if (s == 1 && a == 0 && b == 0) begin
              if (n == 0) exp = stat(0, 1, 1, 1);
              else if (n == 1) exp = 32'hDEAD_0010;
              else if (n == 2) exp = 32'hBEEF_0020;
            end
            rd(4'(n), 4'(s), 3'(a), 3'(b), v);
            check("R7 read decode", v, exp);
          end

    // R7: writes of all ones with a non-matching selector, register number 0
    for (int s = 0; s < 16; s++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++) begin
          if (!(s == 1 && a == 0 && b == 0)) begin
            @(negedge clk);
            reg_num = 0; reg_sub = 4'(s); reg_opa = 3'(a); reg_opb = 3'(b);
            reg_wdata = 32'hFFFF_FFFF; reg_we = 1'b1;
            @(posedge clk);
            rd(0, 1, 0, 0, v);
            check("R7 undecoded write ignored", v, stat(0, 1, 1, 1));
          end
        end
    for (int n = 3; n < 16; n++) begin
      step(0, 0, 1, 4'(n), 32'hFFFF_FFFF);
      rd(0, 1, 0, 0, v);
      check("R7 unused number write ignored", v, stat(0, 1, 1, 1));
    end

    // R2 / R8 / R10: every start state x error x clear mask
    for (int st = 0; st < 8; st++)
      for (int e = 0; e < 2; e++)
        for (int c = 0; c < 8; c++) begin
          logic s0, s1, s2, c0, c1, c2, n0, n1, n2;
          logic [31:0] a0, a1, x;
          do_reset();
          step(1, 32'h1000_0004, 0, 0, 0);
          step(1, 32'h2000_0008, 0, 0, 0);
          step(1, 32'h3000_000C, 0, 0, 0);
          s0 = st[0]; s1 = st[1]; s2 = st[2];
          step(0, 0, 1, 0, {1'b0, ~s2, ~s1, ~s0, 28'h0});
          rd(0, 1, 0, 0, v);
          check("R2 clear to start state", v, stat(0, s2, s1, s0));
          c0 = c[0]; c1 = c[1]; c2 = c[2];
          x = 32'hA5A5_0000 + 32'(st * 16 + e * 8 + c);
          step(1'(e), x, 1, 0, {1'b1, c2, c1, c0, 28'hFFF_FFFF});
          a0 = 32'h1000_0004; a1 = 32'h2000_0008;
          n0 = s0 & ~c0; n1 = s1 & ~c1; n2 = s2 & ~c2;
          if (e == 1) begin
            if (!s0)      begin a0 = x; n0 = 1'b1; end
            else if (!s1) begin a1 = x; n1 = 1'b1; end
            else          n2 = 1'b1;
          end
          rd(0, 1, 0, 0, v); check("R2 R8 R10 status", v, stat(0, n2, n1, n0));
          rd(1, 1, 0, 0, v); check("R4 R8 log0", v, a0);
          rd(2, 1, 0, 0, v); check("R4 R8 log1", v, a1);
        end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule